// File: doc/BRIEF.md
# Machine Check Bank Recorder

This block holds a small set of error-reporting banks for one core, plus a capability word, a global control word and a global status word. Each bank has a control word, a status word, an address word and a miscellaneous word. Error sources present an injection request for one cycle. The request carries a bank index, a new status, a new global status, an address, a miscellaneous value and an unconditional flag. The block evaluates the request against the current register contents in that same cycle. It then records the error, marks only an overflow, ignores it, drops it, rejects it, or escalates to a core reset request.

A recorded uncorrected error also writes the global status and raises a one-cycle machine-check interrupt. Corrected errors never overwrite a bank that still holds a valid uncorrected error. In that case the block sets the overflow bit of the existing status instead. An uncorrected error that cannot be delivered causes an escalation. This happens when machine-check delivery is disabled or a previous machine check is still in progress. The block then asserts a reset request that stays high until its own reset.

A two-state machine governs the block. In `ST_ACTIVE`, requests are judged normally. An escalating request takes the transition `GO_ESCALATE` into `ST_RESET_WAIT`. In that state the reset request is held and every request is rejected. The only exit is the transition `CORE_RESET`, which is the assertion of `rst_n`. A register port lets the owning core write any register, and a combinational read port lets it observe every register.

Top module: `mcb_recorder`

## Requirements
- R1: A request is rejected (code 0, no register change) if the capability is zero, if the bank index is not below the capability's bits [7:0], if the index is not below the number of physical banks, or if status bit 63 (valid) is clear.
- R2: A request with status bit 55 (action required) clear, arriving while global status bit 2 (in progress) is set, is ignored (code 2, no change) unless `inj_uncond` is high. This check comes before the checks of R3 and R4.
- R3: An uncorrected request (status bit 61 set) is dropped (code 1, no change) if capability bit 8 is set and the global control is not all ones. It is also dropped if the bank control is not all ones.
- R4: An uncorrected request that is not dropped escalates (code 5, no bank change) when `mce_en` is low or global status bit 2 is set. `reset_req` then rises together with the result and stays high until `rst_n` is asserted.
- R5: An accepted uncorrected request is recorded (code 3). It writes the bank address, misc and status, and the global status. The stored status gets bit 62 (overflow) set if the old status had bit 63 set. `mce_irq` pulses for one cycle with the result.
- R6: A corrected request to a bank whose old status is not valid, or valid but not uncorrected, is recorded (code 3). It writes address, misc and status, with bit 62 set if the old status was valid. The global status and `mce_irq` are untouched.
- R7: A corrected request to a bank holding a valid uncorrected status gives code 4. Only bit 62 of the existing status is set, and address and misc keep their values.
- R8: Every request sampled at a rising edge produces exactly one `res_valid` pulse, visible in the cycle after that edge. Codes are 0 reject, 1 drop, 2 ignore, 3 record, 4 overflow only, 5 reset.
- R9: While `reset_req` is high, every request is rejected (code 0) with no register change.
- R10: Register selects are 0 capability, 1 global control, 2 global status, 3 bank control, 4 bank status, 5 bank address, 6 bank misc. Writes take effect at the clock edge and reads are combinational. A bank index at or above the physical bank count reads as zero and ignores writes.
- R11: When a host write and a request update the same register at the same edge, the request's value is kept. Host writes to other registers at that edge take effect normally.
- R12: After reset every register reads zero and `res_valid`, `mce_irq` and `reset_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | Injection request present this cycle |
| inj_bank | input | 8 | Target bank index |
| inj_status | input | 64 | New bank status |
| inj_gstatus | input | 64 | New global status for uncorrected records |
| inj_addr | input | 64 | Error address |
| inj_misc | input | 64 | Error miscellaneous value |
| inj_uncond | input | 1 | Bypass the in-progress ignore rule |
| mce_en | input | 1 | Machine-check delivery enabled |
| wr_en | input | 1 | Host register write |
| wr_sel | input | 3 | Host write register select |
| wr_bank | input | 8 | Host write bank index |
| wr_data | input | 64 | Host write data |
| rd_sel | input | 3 | Read register select |
| rd_bank | input | 8 | Read bank index |
| rd_data | output | 64 | Read data |
| res_valid | output | 1 | Outcome valid pulse |
| res_code | output | 3 | Outcome code |
| mce_irq | output | 1 | Machine-check interrupt pulse |
| reset_req | output | 1 | Held core reset request |

## Verification
A host register write and an injection commit can land on the same edge, and may even target the same register. The bench drives both in one cycle. In one case the write and the injection hit the same bank address word; in the other they hit different banks. It then reads back the registers and expects the injected value to win the shared word while the unrelated write lands intact. The bench also has a request arrive in the same cycle the host has just set the in-progress bit. In that case the ignore and escalate rules must see the already-updated global status.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
    localparam int DW     = 64;
    localparam int IDX_W  = 8;
    localparam int VAL_B  = 63;
    localparam int OVER_B = 62;
    localparam int UC_B   = 61;
    localparam int AR_B   = 55;
    localparam int MCIP_B = 2;
    localparam int CTLP_B = 8;

    typedef enum logic [2:0] {
        OC_REJECT    = 3'd0,
        OC_DROP      = 3'd1,
        OC_IGNORE    = 3'd2,
        OC_RECORD    = 3'd3,
        OC_OVER_ONLY = 3'd4,
        OC_RESET     = 3'd5
    } outcome_e;

    typedef enum logic [2:0] {
        SEL_CAP   = 3'd0,
        SEL_GCTL  = 3'd1,
        SEL_GSTAT = 3'd2,
        SEL_BCTL  = 3'd3,
        SEL_BSTAT = 3'd4,
        SEL_BADDR = 3'd5,
        SEL_BMISC = 3'd6
    } reg_sel_e;

    typedef enum logic {
        ST_ACTIVE     = 1'b0,
        ST_RESET_WAIT = 1'b1
    } mcb_state_e;
endpackage

// File: rtl/mcb_judge.sv
module mcb_judge
    import mcb_pkg::*;
(
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_bank,
    input  logic [DW-1:0]     req_status,
    input  logic              req_uncond,
    input  logic              bank_exists,
    input  logic              pending,
    input  logic              mce_en,
    input  logic [DW-1:0]     cap,
    input  logic [DW-1:0]     gctl,
    input  logic [DW-1:0]     gstat,
    input  logic [DW-1:0]     old_status,
    input  logic [DW-1:0]     bank_ctl,
    output outcome_e          code,
    output logic              st_we,
    output logic              am_we,
    output logic              gstat_we,
    output logic              raise_irq,
    output logic              escalate,
    output logic [DW-1:0]     st_new
);
    localparam logic [DW-1:0] OVER_M = DW'(1) << OVER_B;

    logic is_uc, is_ar, mcip, old_val, old_uc, bad_index;

    assign is_uc     = req_status[UC_B];
    assign is_ar     = req_status[AR_B];
    assign mcip      = gstat[MCIP_B];
    assign old_val   = old_status[VAL_B];
    assign old_uc    = old_status[UC_B];
    assign bad_index = (req_bank >= cap[IDX_W-1:0]) || !bank_exists;

    always_comb begin
        code      = OC_REJECT;
        st_we     = 1'b0;
        am_we     = 1'b0;
        gstat_we  = 1'b0;
        raise_irq = 1'b0;
        escalate  = 1'b0;
        st_new    = req_status | (old_val ? OVER_M : '0);
        if (req_valid) begin
            if (pending || (cap == '0) || bad_index || !req_status[VAL_B]) begin
                code = OC_REJECT;
            end else if (!req_uncond && !is_ar && mcip) begin
                code = OC_IGNORE;
            end else if (is_uc) begin
                if ((cap[CTLP_B] && !(&gctl)) || !(&bank_ctl)) begin
                    code = OC_DROP;
                end else if (!mce_en || mcip) begin
                    code     = OC_RESET;
                    escalate = 1'b1;
                end else begin
                    code      = OC_RECORD;
                    st_we     = 1'b1;
                    am_we     = 1'b1;
                    gstat_we  = 1'b1;
                    raise_irq = 1'b1;
                end
            end else if (!old_val || !old_uc) begin
                code  = OC_RECORD;
                st_we = 1'b1;
                am_we = 1'b1;
            end else begin
                code   = OC_OVER_ONLY;
                st_we  = 1'b1;
                st_new = old_status | OVER_M;
            end
        end
    end
endmodule

// File: rtl/mcb_bank_file.sv
module mcb_bank_file
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [IDX_W-1:0]  wr_bank,
    input  logic [DW-1:0]     wr_data,
    input  logic [IDX_W-1:0]  inj_bank,
    input  logic              inj_st_we,
    input  logic              inj_am_we,
    input  logic [DW-1:0]     inj_status,
    input  logic [DW-1:0]     inj_addr,
    input  logic [DW-1:0]     inj_misc,
    output logic [DW-1:0]     peek_ctl,
    output logic [DW-1:0]     peek_status,
    input  reg_sel_e          rd_sel,
    input  logic [IDX_W-1:0]  rd_bank,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] ctl_v  [NUM_BANKS];
    logic [DW-1:0] st_v   [NUM_BANKS];
    logic [DW-1:0] addr_v [NUM_BANKS];
    logic [DW-1:0] misc_v [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [DW-1:0] ctl_q, st_q, addr_q, misc_q;
        logic hit_w, hit_i;

        assign hit_w = wr_en && (wr_bank == IDX_W'(g));
        assign hit_i = (inj_bank == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q  <= '0;
                st_q   <= '0;
                addr_q <= '0;
                misc_q <= '0;
            end else begin
                if (hit_w && wr_sel == SEL_BCTL) ctl_q <= wr_data;
                if (hit_i && inj_st_we)          st_q <= inj_status;
                else if (hit_w && wr_sel == SEL_BSTAT) st_q <= wr_data;
                if (hit_i && inj_am_we) begin
                    addr_q <= inj_addr;
                    misc_q <= inj_misc;
                end else begin
                    if (hit_w && wr_sel == SEL_BADDR) addr_q <= wr_data;
                    if (hit_w && wr_sel == SEL_BMISC) misc_q <= wr_data;
                end
            end
        end

        assign ctl_v[g]  = ctl_q;
        assign st_v[g]   = st_q;
        assign addr_v[g] = addr_q;
        assign misc_v[g] = misc_q;
    end

    always_comb begin
        peek_ctl    = '0;
        peek_status = '0;
        rd_data     = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (inj_bank == IDX_W'(i)) begin
                peek_ctl    = ctl_v[i];
                peek_status = st_v[i];
            end
            if (rd_bank == IDX_W'(i)) begin
                unique case (rd_sel)
                    SEL_BCTL:  rd_data = ctl_v[i];
                    SEL_BSTAT: rd_data = st_v[i];
                    SEL_BADDR: rd_data = addr_v[i];
                    SEL_BMISC: rd_data = misc_v[i];
                    default:   rd_data = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mcb_recorder.sv
module mcb_recorder
    import mcb_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inj_valid,
    input  logic [7:0]  inj_bank,
    input  logic [63:0] inj_status,
    input  logic [63:0] inj_gstatus,
    input  logic [63:0] inj_addr,
    input  logic [63:0] inj_misc,
    input  logic        inj_uncond,
    input  logic        mce_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_bank,
    input  logic [63:0] wr_data,
    input  logic [2:0]  rd_sel,
    input  logic [7:0]  rd_bank,
    output logic [63:0] rd_data,
    output logic        res_valid,
    output logic [2:0]  res_code,
    output logic        mce_irq,
    output logic        reset_req
);
    reg_sel_e      wsel, rsel;
    mcb_state_e    state_q, state_d;
    logic [DW-1:0] cap_q, gctl_q, gstat_q;
    logic [DW-1:0] peek_ctl, peek_status, bank_rd, st_new;
    logic          bank_exists, st_we, am_we, gstat_we, raise_irq, escalate;
    outcome_e      code;

    assign wsel        = reg_sel_e'(wr_sel);
    assign rsel        = reg_sel_e'(rd_sel);
    assign bank_exists = (32'(inj_bank) < NUM_BANKS);

    mcb_judge u_judge (
        .req_valid   (inj_valid),
        .req_bank    (inj_bank),
        .req_status  (inj_status),
        .req_uncond  (inj_uncond),
        .bank_exists (bank_exists),
        .pending     (state_q == ST_RESET_WAIT),
        .mce_en      (mce_en),
        .cap         (cap_q),
        .gctl        (gctl_q),
        .gstat       (gstat_q),
        .old_status  (peek_status),
        .bank_ctl    (peek_ctl),
        .code        (code),
        .st_we       (st_we),
        .am_we       (am_we),
        .gstat_we    (gstat_we),
        .raise_irq   (raise_irq),
        .escalate    (escalate),
        .st_new      (st_new)
    );

    mcb_bank_file #(.NUM_BANKS(NUM_BANKS)) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wsel),
        .wr_bank     (wr_bank),
        .wr_data     (wr_data),
        .inj_bank    (inj_bank),
        .inj_st_we   (st_we),
        .inj_am_we   (am_we),
        .inj_status  (st_new),
        .inj_addr    (inj_addr),
        .inj_misc    (inj_misc),
        .peek_ctl    (peek_ctl),
        .peek_status (peek_status),
        .rd_sel      (rsel),
        .rd_bank     (rd_bank),
        .rd_data     (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= '0;
            gctl_q  <= '0;
            gstat_q <= '0;
        end else begin
            if (wr_en && wsel == SEL_CAP)  cap_q  <= wr_data;
            if (wr_en && wsel == SEL_GCTL) gctl_q <= wr_data;
            if (gstat_we)                          gstat_q <= inj_gstatus;
            else if (wr_en && wsel == SEL_GSTAT)   gstat_q <= wr_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE:     if (escalate) state_d = ST_RESET_WAIT;
            ST_RESET_WAIT: state_d = ST_RESET_WAIT;
            default:       state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= 3'd0;
            mce_irq   <= 1'b0;
        end else begin
            res_valid <= inj_valid;
            res_code  <= inj_valid ? code : OC_REJECT;
            mce_irq   <= raise_irq;
        end
    end

    assign reset_req = (state_q == ST_RESET_WAIT);

    always_comb begin
        unique case (rsel)
            SEL_CAP:   rd_data = cap_q;
            SEL_GCTL:  rd_data = gctl_q;
            SEL_GSTAT: rd_data = gstat_q;
            default:   rd_data = bank_rd;
        endcase
    end
endmodule

// File: rtl/mcb_recorder_chk.sv
module mcb_recorder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        inj_valid,
    input logic [63:0] inj_status,
    input logic        res_valid,
    input logic [2:0]  res_code,
    input logic        mce_irq,
    input logic        reset_req
);
    AST_RES_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |=> res_valid); // R8
    AST_RES_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(inj_valid)); // R8
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code <= 3'd5)); // R8
    AST_INVALID_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_status[63]) |=> (res_code == 3'd0)); // R1
    AST_IRQ_ON_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
        mce_irq |-> (res_valid && res_code == 3'd3)); // R5
    AST_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req); // R4
    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> (res_valid && res_code == 3'd5)); // R4
    AST_PENDING_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && inj_valid) |=> (res_code == 3'd0)); // R9
endmodule

bind mcb_recorder mcb_recorder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inj_valid  (inj_valid),
    .inj_status (inj_status),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .mce_irq    (mce_irq),
    .reset_req  (reset_req)
);

// File: tb/mcb_recorder_tb.sv
module mcb_recorder_tb;
    localparam logic [63:0] VAL  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] OVR  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] UC   = 64'h2000_0000_0000_0000;
    localparam logic [63:0] AR   = 64'h0080_0000_0000_0000;
    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inj_valid = 1'b0, inj_uncond = 1'b0, mce_en = 1'b1, wr_en = 1'b0;
    logic [7:0]  inj_bank = '0, wr_bank = '0, rd_bank = '0;
    logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0, wr_data = '0;
    logic [2:0]  wr_sel = '0, rd_sel = '0;
    logic [63:0] rd_data;
    logic        res_valid, mce_irq, reset_req;
    logic [2:0]  res_code;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mcb_recorder u_dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, input logic [7:0] bank, output logic [63:0] d);
        rd_sel = sel; rd_bank = bank; #1; d = rd_data;
    endtask

    task automatic chk_reg(string tag, logic [2:0] sel, logic [7:0] bank, logic [63:0] exp);
        logic [63:0] d;
        rd(sel, bank, d);
        chk(tag, d, exp);
    endtask

    task automatic wr(logic [2:0] sel, logic [7:0] bank, logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_bank = bank; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic inject(string tag, logic [7:0] bank, logic [63:0] st, logic [63:0] gst,
                          logic [63:0] ad, logic [63:0] mi, logic unc,
                          logic [2:0] exp_code, logic exp_irq);
        @(negedge clk);
        inj_valid = 1; inj_bank = bank; inj_status = st; inj_gstatus = gst;
        inj_addr = ad; inj_misc = mi; inj_uncond = unc;
        @(negedge clk);
        inj_valid = 0; inj_uncond = 0;
        chk({tag, " R8 res_valid"}, 64'(res_valid), 64'd1);
        chk({tag, " code"}, 64'(res_code), 64'(exp_code));
        chk({tag, " irq"}, 64'(mce_irq), 64'(exp_irq));
        @(negedge clk);
        chk({tag, " R8 single pulse"}, 64'(res_valid), 64'd0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic configure();
        wr(3'd0, 8'd0, 64'h104);
        wr(3'd1, 8'd0, ONES);
        for (int b = 0; b < 4; b++) wr(3'd3, 8'(b), ONES);
    endtask

    task automatic t_reset_state();
        chk("R12 reset_req", 64'(reset_req), 0);
        chk("R12 res_valid", 64'(res_valid), 0);
        chk("R12 irq", 64'(mce_irq), 0);
        chk_reg("R12 cap", 3'd0, 0, 0);
        chk_reg("R12 gstat", 3'd2, 0, 0);
        chk_reg("R12 bank0 status", 3'd4, 0, 0);
    endtask

    task automatic t_regs();
        configure();
        chk_reg("R10 cap readback", 3'd0, 0, 64'h104);
        chk_reg("R10 bank ctl readback", 3'd3, 8'd2, ONES);
        wr(3'd3, 8'd5, ONES);
        chk_reg("R10 absent bank reads zero", 3'd3, 8'd5, 0);
    endtask

    task automatic t_reject();
        inject("R1 bank>=count", 8'd4, VAL | 1, 0, 0, 0, 0, 3'd0, 0);
        inject("R1 valid clear", 8'd0, 64'h11, 0, 0, 0, 0, 3'd0, 0);
        wr(3'd0, 0, 64'h108);
        inject("R1 bank not physical", 8'd5, VAL | 1, 0, 0, 0, 0, 3'd0, 0);
        wr(3'd0, 0, 0);
        inject("R1 cap zero", 8'd0, VAL | 1, 0, 0, 0, 0, 3'd0, 0);
        wr(3'd0, 0, 64'h104);
        chk_reg("R1 bank0 untouched", 3'd4, 0, 0);
    endtask

    task automatic t_corrected();
        inject("R6 first corrected", 0, VAL | 64'h11, 64'h7, 64'h1000, 64'h20, 0, 3'd3, 0);
        chk_reg("R6 status", 3'd4, 0, VAL | 64'h11);
        chk_reg("R6 addr", 3'd5, 0, 64'h1000);
        chk_reg("R6 gstat untouched", 3'd2, 0, 0);
        inject("R6 second corrected", 0, VAL | 64'h22, 0, 64'h2000, 64'h30, 0, 3'd3, 0);
        chk_reg("R6 overflow added", 3'd4, 0, VAL | OVR | 64'h22);
        chk_reg("R6 misc", 3'd6, 0, 64'h30);
    endtask

    task automatic t_uc_record();
        inject("R5 uc record", 1, VAL | UC | AR | 64'h33, 64'h5, 64'h3000, 64'h3, 0, 3'd3, 1);
        chk_reg("R5 status", 3'd4, 1, VAL | UC | AR | 64'h33);
        chk_reg("R5 gstat", 3'd2, 0, 64'h5);
        chk_reg("R5 addr", 3'd5, 1, 64'h3000);
        wr(3'd2, 0, 0);
        inject("R5 uc over valid", 1, VAL | UC | AR | 64'h44, 64'h1, 64'h4000, 64'h4, 0, 3'd3, 1);
        chk_reg("R5 overflow set", 3'd4, 1, VAL | OVR | UC | AR | 64'h44);
        chk_reg("R5 gstat2", 3'd2, 0, 64'h1);
    endtask

    task automatic t_over_only();
        inject("R7 seed uc", 2, VAL | UC | AR | 64'h66, 0, 64'h6000, 64'h6, 0, 3'd3, 1);
        inject("R7 corrected onto uc", 2, VAL | 64'h55, 0, 64'h5000, 64'h5, 0, 3'd4, 0);
        chk_reg("R7 status", 3'd4, 2, VAL | OVR | UC | AR | 64'h66);
        chk_reg("R7 addr kept", 3'd5, 2, 64'h6000);
    endtask

    task automatic t_drop();
        wr(3'd3, 3, 0);
        inject("R3 bank ctl", 3, VAL | UC | AR, 0, 1, 1, 0, 3'd1, 0);
        wr(3'd3, 3, ONES);
        wr(3'd1, 0, 0);
        inject("R3 global ctl", 3, VAL | UC | AR, 0, 1, 1, 0, 3'd1, 0);
        chk_reg("R3 bank3 untouched", 3'd4, 3, 0);
        wr(3'd0, 0, 64'h004);
        inject("R3 ctl not present", 3, VAL | UC | AR | 64'h77, 0, 64'h7000, 7, 0, 3'd3, 1);
        chk_reg("R3 recorded", 3'd4, 3, VAL | UC | AR | 64'h77);
        wr(3'd0, 0, 64'h104);
        wr(3'd1, 0, ONES);
    endtask

    task automatic t_ignore();
        wr(3'd2, 0, 64'h4);
        inject("R2 ignored", 0, VAL | 64'h88, 0, 64'h8000, 8, 0, 3'd2, 0);
        chk_reg("R2 unchanged", 3'd4, 0, VAL | OVR | 64'h22);
        inject("R2 uc no ar ignored", 3, VAL | UC | 64'h1, 0, 0, 0, 0, 3'd2, 0);
        chk("R2 no escalation", 64'(reset_req), 0);
        inject("R2 uncond", 0, VAL | 64'h88, 0, 64'h8000, 8, 1, 3'd3, 0);
        chk_reg("R2 recorded", 3'd4, 0, VAL | OVR | 64'h88);
    endtask

    task automatic t_collide(string tag, logic [2:0] sel, logic [7:0] wb, logic [63:0] wd);
        @(negedge clk);
        inj_valid = 1; inj_bank = 0; inj_status = VAL | AR | 64'h99; inj_gstatus = 0;
        inj_addr = 64'h9999; inj_misc = 64'h9;
        wr_en = 1; wr_sel = sel; wr_bank = wb; wr_data = wd;
        @(negedge clk);
        inj_valid = 0; wr_en = 0;
        chk({tag, " code"}, 64'(res_code), 3);
    endtask

    task automatic t_same_cycle();
        t_collide("R11 same reg", 3'd5, 0, 64'hAAAA);
        chk_reg("R11 injection wins addr", 3'd5, 0, 64'h9999);
        t_collide("R11 other reg", 3'd6, 2, 64'h77);
        chk_reg("R11 host misc lands", 3'd6, 2, 64'h77);
        chk_reg("R11 status", 3'd4, 0, VAL | OVR | AR | 64'h99);
    endtask

    task automatic t_escalate();
        mce_en = 0;
        inject("R4 mce disabled", 0, VAL | UC | AR | 64'hA, 0, 0, 0, 0, 3'd5, 0);
        chk("R4 reset_req", 64'(reset_req), 1);
        chk_reg("R4 bank untouched", 3'd4, 0, VAL | OVR | AR | 64'h99);
        mce_en = 1;
        inject("R9 pending reject", 1, VAL | 64'h1, 0, 0, 0, 0, 3'd0, 0);
        chk("R4 held", 64'(reset_req), 1);
        chk_reg("R9 bank1 untouched", 3'd4, 1, VAL | OVR | UC | AR | 64'h44);
        do_reset();
        chk("R12 reset clears request", 64'(reset_req), 0);
        chk_reg("R12 bank cleared", 3'd4, 0, 0);
        configure();
        wr(3'd2, 0, 64'h4);
        inject("R4 mcip nested", 2, VAL | UC | AR | 64'hB, 0, 0, 0, 0, 3'd5, 0);
        chk("R4 reset_req mcip", 64'(reset_req), 1);
        chk_reg("R4 bank2 untouched", 3'd4, 2, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_regs();
        t_reject();
        t_corrected();
        t_uc_record();
        t_over_only();
        t_drop();
        t_ignore();
        t_same_cycle();
        t_escalate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule